// File: doc/BRIEF.md
# Power-of-Two Clock-Enable Divider

The block turns a fast clock into a one-cycle enable pulse that repeats every 2^k input cycles. The downstream logic clocks on the fast clock and acts only on cycles where the pulse is high. The exponent k is written through a small configuration port. A code write only stages the new exponent and turns the divider off in the same write. The staged exponent becomes the running one only when a later write turns the enable bit from 0 to 1. The ratio can therefore never change in the middle of a period.

One parameter, the largest legal exponent, sets each instance. A value of 3 suits a peripheral clock (divide by 8). A value of 7 suits a debounce clock (divide by 128). A value of 15 suits a clock derived from a slow timer (divide by 32768). A consumer that needs the divided frequency shifts the base rate right by the active code, which the block reports together with the staged code. A code above the instance limit is clamped to the limit and sets a sticky error flag.

Top module: `pow2_tick_div`

## Requirements
- R1: While running with active code k, `tick_o` is high for exactly one cycle in every 2^k cycles, and low in the other cycles.
- R2: A write with `cfg_code_we`=1 updates `code_staged_o` at the next edge and leaves `code_active_o` unchanged.
- R3: A write with `cfg_code_we`=1 forces `enabled_o` to 0 at the same edge, whatever `cfg_en` holds, and `tick_o` is low from that edge on.
- R4: A write with `cfg_code_we`=0 and `cfg_en`=1 while `enabled_o` is 0 copies the staged code into `code_active_o` and restarts the count. `tick_o` is low after that edge and first goes high 2^k edges after it.
- R5: A write with `cfg_en`=1 while `enabled_o` is already 1 does not restart the count, so the tick cadence continues without a shift.
- R6: While `enabled_o` is 0, `tick_o` stays low.
- R7: A staged code above CODE_MAX is stored as CODE_MAX and sets `code_err_o`, which stays set until reset.
- R8: After reset, `tick_o`, `enabled_o` and `code_err_o` are 0, and both codes read 0.
- R9: With active code 0, `tick_o` is high on every cycle while running.
- R10: A write with `cfg_code_we`=0 and `cfg_en`=0 clears `enabled_o` at that edge, and `tick_o` is low from that edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_code_we | input | 1 | 1: write the code field (clears enable); 0: write the enable bit |
| cfg_code | input | CODE_W | Exponent value to stage |
| cfg_en | input | 1 | Enable bit value for an enable write |
| tick_o | output | 1 | One-cycle divided enable pulse |
| enabled_o | output | 1 | Current enable bit |
| code_staged_o | output | AW | Staged exponent, after clamping |
| code_active_o | output | AW | Exponent currently in force |
| code_err_o | output | 1 | Sticky flag: an out-of-range code was written |

## Verification
A corrupted count or mask shows up as a pulse spacing that differs from 2^k. This is visible within one period of the active ratio, which is at most 128 cycles in the swept setup. A wrong apply path appears at once in `code_active_o`, on the edge after the enable write, and again at the first pulse. A missed restart shifts that first pulse away from exactly 2^k edges. Stale enable state gives a pulse on the cycle after a code write or a disable write.

// File: rtl/pow2_tick_div_pkg.sv
package pow2_tick_div_pkg;

    // Control handed from the configuration stage to the counter stage.
    typedef struct packed {
        logic apply;    // enable goes 0->1 on this edge
        logic run_q;    // enable as currently registered
        logic run_nxt;  // enable after this edge
    } pdiv_ctl_t;

    // Clamp a requested exponent to the instance limit.
    function automatic int unsigned clamp_code(int unsigned raw, int unsigned lim);
        return (raw > lim) ? lim : raw;
    endfunction

    function automatic logic code_over(int unsigned raw, int unsigned lim);
        return raw > lim;
    endfunction

endpackage

// File: rtl/pow2_tick_div_cfg.sv
module pow2_tick_div_cfg
    import pow2_tick_div_pkg::*;
#(
    parameter int CODE_MAX = 7,
    parameter int CODE_W   = 4,
    parameter int AW       = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic              cfg_code_we,
    input  logic [CODE_W-1:0] cfg_code,
    input  logic              cfg_en,
    output pdiv_ctl_t         ctl,
    output logic [AW-1:0]     staged,
    output logic [AW-1:0]     active,
    output logic              err
);

    logic code_wr, en_wr, en_q, en_nxt, apply;

    always_comb begin
        code_wr = cfg_wr & cfg_code_we;
        en_wr   = cfg_wr & ~cfg_code_we;
        apply   = en_wr & cfg_en & ~en_q;
        if (code_wr)
            en_nxt = 1'b0;
        else if (en_wr)
            en_nxt = cfg_en;
        else
            en_nxt = en_q;
        ctl.apply   = apply;
        ctl.run_q   = en_q;
        ctl.run_nxt = en_nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            staged <= '0;
            active <= '0;
            err    <= 1'b0;
        end else begin
            en_q <= en_nxt;
            if (code_wr) begin
                staged <= AW'(clamp_code(32'(cfg_code), CODE_MAX));
                if (code_over(32'(cfg_code), CODE_MAX))
                    err <= 1'b1;
            end
            if (apply)
                active <= staged;
        end
    end

    assert_stage_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !code_wr |=> $stable(staged));
    assert_code_clears_en_R3: assert property (@(posedge clk) disable iff (rst)
        code_wr |=> !en_q);
    assert_active_only_on_rise_R4: assert property (@(posedge clk) disable iff (rst)
        !(en_wr && cfg_en && !en_q) |=> $stable(active));
    assert_stage_in_range_R7: assert property (@(posedge clk) disable iff (rst)
        32'(staged) <= CODE_MAX);
    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

endmodule

// File: rtl/pow2_tick_div_cnt.sv
module pow2_tick_div_cnt
    import pow2_tick_div_pkg::*;
#(
    parameter int CODE_MAX = 7,
    parameter int AW       = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  pdiv_ctl_t     ctl,
    input  logic [AW-1:0] code,
    output logic          tick
);

    localparam int CNT_W = (CODE_MAX < 1) ? 1 : CODE_MAX;

    logic [CNT_W-1:0] mask;
    logic [CNT_W-1:0] cnt;
    logic             wrap;

    // Low k bits of the mask set for exponent k.
    for (genvar i = 0; i < CNT_W; i++) begin : g_mask
        assign mask[i] = (32'(code) > i);
    end

    assign wrap = (cnt == mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else begin
            tick <= ctl.run_q & ctl.run_nxt & wrap;
            if (ctl.apply)
                cnt <= '0;
            else if (ctl.run_q & ctl.run_nxt)
                cnt <= (cnt + 1'b1) & mask;
        end
    end

    assert_tick_needs_run_R6: assert property (@(posedge clk) disable iff (rst)
        tick |-> ctl.run_q);
    assert_cnt_in_mask_R1: assert property (@(posedge clk) disable iff (rst)
        ctl.run_q |-> ((cnt & ~mask) == '0));
    assert_restart_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        ctl.apply |=> !tick);

endmodule

// File: rtl/pow2_tick_div.sv
module pow2_tick_div
    import pow2_tick_div_pkg::*;
#(
    parameter  int CODE_MAX = 7,
    parameter  int CODE_W   = 4,
    localparam int AW       = $clog2(CODE_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic              cfg_code_we,
    input  logic [CODE_W-1:0] cfg_code,
    input  logic              cfg_en,
    output logic              tick_o,
    output logic              enabled_o,
    output logic [AW-1:0]     code_staged_o,
    output logic [AW-1:0]     code_active_o,
    output logic              code_err_o
);

    pdiv_ctl_t ctl;

    pow2_tick_div_cfg #(
        .CODE_MAX(CODE_MAX),
        .CODE_W  (CODE_W),
        .AW      (AW)
    ) u_cfg (
        .clk        (clk),
        .rst        (rst),
        .cfg_wr     (cfg_wr),
        .cfg_code_we(cfg_code_we),
        .cfg_code   (cfg_code),
        .cfg_en     (cfg_en),
        .ctl        (ctl),
        .staged     (code_staged_o),
        .active     (code_active_o),
        .err        (code_err_o)
    );

    pow2_tick_div_cnt #(
        .CODE_MAX(CODE_MAX),
        .AW      (AW)
    ) u_cnt (
        .clk (clk),
        .rst (rst),
        .ctl (ctl),
        .code(code_active_o),
        .tick(tick_o)
    );

    assign enabled_o = ctl.run_q;

    assert_reset_quiet_R8: assert property (@(posedge clk)
        $past(rst) |-> (!tick_o && !enabled_o && !code_err_o));

endmodule

// File: tb/sim_pow2_tick_div.sv
module sim_pow2_tick_div;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_wr = 1'b0;
    logic       cfg_code_we = 1'b0;
    logic [3:0] cfg_code = '0;
    logic       cfg_en = 1'b0;
    logic       tick_o, enabled_o, code_err_o;
    logic [2:0] code_staged_o, code_active_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pow2_tick_div #(.CODE_MAX(7), .CODE_W(4)) u0 (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_code_we(cfg_code_we),
        .cfg_code(cfg_code), .cfg_en(cfg_en), .tick_o(tick_o),
        .enabled_o(enabled_o), .code_staged_o(code_staged_o),
        .code_active_o(code_active_o), .code_err_o(code_err_o)
    );

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // All tasks are entered at a negedge and return at the next negedge.
    task automatic wr_code(int c);
        cfg_wr = 1; cfg_code_we = 1; cfg_code = 4'(c); cfg_en = 1;
        @(negedge clk);
        cfg_wr = 0; cfg_code_we = 0; cfg_en = 0;
    endtask

    task automatic wr_en(bit v);
        cfg_wr = 1; cfg_code_we = 0; cfg_en = v;
        @(negedge clk);
        cfg_wr = 0; cfg_en = 0;
    endtask

    // Check the tick over cycles k = k0+1 .. k1 after an apply at k = 0.
    task automatic run_chk(string req, int n, int k0, int k1);
        for (int k = k0 + 1; k <= k1; k++) begin
            @(negedge clk);
            chk(req, int'(tick_o), (k % n == 0) ? 1 : 0);
        end
    endtask

    task automatic quiet_chk(string req, int cyc);
        for (int k = 0; k < cyc; k++) begin
            @(negedge clk);
            chk(req, int'(tick_o), 0);
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int prev;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R8 reset state
        chk("R8 tick", int'(tick_o), 0);
        chk("R8 en", int'(enabled_o), 0);
        chk("R8 err", int'(code_err_o), 0);
        chk("R8 staged", int'(code_staged_o), 0);
        chk("R8 active", int'(code_active_o), 0);

        // Sweep every legal exponent: R1, R2, R3, R4, R9
        prev = 0;
        for (int c = 0; c <= 7; c++) begin
            wr_code(c);
            chk("R2 staged", int'(code_staged_o), c);
            chk("R2 active kept", int'(code_active_o), prev);
            chk("R3 en cleared", int'(enabled_o), 0);
            chk("R3 tick low", int'(tick_o), 0);
            wr_en(1);
            chk("R4 active", int'(code_active_o), c);
            chk("R4 tick low at apply", int'(tick_o), 0);
            if (c == 0) run_chk("R9", 1, 0, 10);
            else        run_chk("R1", 1 << c, 0, 3 * (1 << c));
            prev = c;
        end

        // R5: re-write enable=1 while running, cadence must not shift
        wr_code(2);
        wr_en(1);
        run_chk("R5 before", 4, 0, 2);
        wr_en(1);
        chk("R5 at rewrite", int'(tick_o), 0);
        run_chk("R5 after", 4, 3, 14);

        // R10 and R6: disable write stops ticks, state held
        wr_en(0);
        chk("R10 en", int'(enabled_o), 0);
        chk("R10 tick", int'(tick_o), 0);
        quiet_chk("R6 idle", 20);
        chk("R6 active kept", int'(code_active_o), 2);

        // R3: code write while running stops ticks
        wr_en(1);
        run_chk("R4 re-apply", 4, 0, 5);
        wr_code(5);
        chk("R3 en", int'(enabled_o), 0);
        chk("R3 active kept", int'(code_active_o), 2);
        quiet_chk("R3 quiet", 20);

        // R7: out-of-range code clamps and sets sticky error
        wr_code(12);
        chk("R7 clamp", int'(code_staged_o), 7);
        chk("R7 err", int'(code_err_o), 1);
        wr_en(1);
        chk("R7 active", int'(code_active_o), 7);
        run_chk("R7 ratio", 128, 0, 256);
        wr_code(3);
        chk("R7 sticky", int'(code_err_o), 1);
        chk("R7 legal staged", int'(code_staged_o), 3);
        wr_code(15);
        chk("R7 clamp max", int'(code_staged_o), 7);

        // R8: reset clears everything again
        rst = 1;
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R8 err cleared", int'(code_err_o), 0);
        chk("R8 staged cleared", int'(code_staged_o), 0);
        chk("R8 active cleared", int'(code_active_o), 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule